// File: doc/BRIEF.md
# Packet-Atomic Readback FIFO

This block buffers configuration readback data for a bus that drains it one 32-bit word at a time. Data arrives from a row interface as packets of four words. A packet is taken only if the whole packet fits, so the buffer never holds a partial packet. If the space is too small, the block discards the packet and raises a sticky error.

The block copies an accepted packet into a staging register. It then writes the four words into a block-RAM store on the next four clock cycles, word 0 first. While the staging register is busy, the packet input reports not-ready, and a packet offered in that time has no effect.

The free count covers words that are stored and words that are staged but not yet written. This keeps the all-or-nothing rule exact. A read strobe pops one word, and the data appears on the next cycle. A read of an empty buffer returns zero and leaves every state unchanged.

Top module: `rbf_top`

## Requirements
- R1: After a synchronous reset, `empty`=1, `free_words`=DEPTH (2048), `drop_err`=0, `pkt_ready`=1 and `rd_data`=0.
- R2: The words of an accepted packet are read back in order: word 0 (bits 31:0 of `pkt_data`) first, then bits 63:32, 95:64 and 127:96.
- R3: A packet offered with `pkt_ready`=1 while `free_words` < 4 is discarded. Nothing is stored, and `free_words` changes only through a pop in that same cycle.
- R4: A read while `empty`=1 sets `rd_data` to 0 one cycle later. It changes neither `free_words` nor `empty`.
- R5: For a read while `empty`=0, `rd_data` one cycle later holds the oldest stored word. `rd_data` holds its value in cycles without a read.
- R6: An accepted packet lowers `free_words` by 4 at the accepting edge, and each pop of a stored word raises it by 1.
- R7: `pkt_ready` is low for exactly the four cycles after an accepting edge. A packet offered while `pkt_ready`=0 is ignored.
- R8: `empty` goes low one cycle after an accepting edge, as soon as word 0 has been written.
- R9: `drop_err` sets on a discard and stays set until `drop_err_clr`=1. A discard in the same cycle as a clear leaves it set.
- R10: When a packet is offered in the same cycle as a pop, the space check uses `free_words` as it was before the pop.
- R11: The store holds exactly DEPTH words: 512 packets are accepted from empty and bring `free_words` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet is offered this cycle |
| pkt_data | input | 128 | Four packet words, word 0 in the low 32 bits |
| pkt_ready | output | 1 | Staging register is idle; an offered packet is evaluated |
| rd_req | input | 1 | Read strobe; pops one word |
| rd_data | output | 32 | Data of the last read, or 0 if that read found the store empty |
| empty | output | 1 | No word is stored |
| free_words | output | 12 | Words not stored and not reserved by staging |
| drop_err | output | 1 | Sticky packet-discard flag |
| drop_err_clr | input | 1 | Clears `drop_err` (write one to clear) |

## Verification
The bench drives the store to exactly full and checks that the last packet fits. A space check that is off by one would drop that packet or accept a fifth word past the end. It offers a packet with three words free in the same cycle as a pop. A design that let the pop count toward the check would accept a packet it has no room for. The bench also reads the empty store and offers packets while staging is busy. It checks that neither stimulus changes `rd_data`, the count or the stored order, which exposes a pointer advancing on a null pop or a staging register that gets overwritten. It also raises a discard in the same cycle as an error clear to check that the set wins.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } stage_st_e;
endpackage

// File: rtl/rbf_stager.sv
module rbf_stager #(
  parameter int DATA_W    = 32,
  parameter int PKT_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [PKT_WORDS*DATA_W-1:0]   pkt_data,
  output logic                          busy,
  output logic                          wr_en,
  output logic [DATA_W-1:0]             wr_data
);
  import rbf_pkg::*;

  localparam int IDX_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

  stage_st_e                             st_q;
  logic [IDX_W-1:0]                      idx_q;
  logic [PKT_WORDS-1:0][DATA_W-1:0]      stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      stage_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load) begin
            stage_q <= pkt_data;
            idx_q   <= '0;
            st_q    <= ST_DRAIN;
          end
        end
        default: begin
          if (idx_q == LAST_IDX) begin
            st_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign wr_en   = (st_q == ST_DRAIN);
  assign busy    = wr_en;
  assign wr_data = stage_q[idx_q];
endmodule

// File: rtl/rbf_ram.sv
module rbf_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2048
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [DATA_W-1:0]          rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/rbf_ctrl.sv
module rbf_ctrl #(
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pkt_valid,
  input  logic                          stage_busy,
  input  logic                          wr_en,
  input  logic                          rd_req,
  input  logic                          err_clr,
  output logic                          load,
  output logic                          pop,
  output logic [$clog2(DEPTH)-1:0]      wr_addr,
  output logic [$clog2(DEPTH)-1:0]      rd_addr,
  output logic                          empty,
  output logic [$clog2(DEPTH+1)-1:0]    free_words,
  output logic                          drop_err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] PKT_CNT = CNT_W'(PKT_WORDS);

  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] level_q, free_q;
  logic             err_q;
  logic             offer, drop;

  assign offer = pkt_valid && !stage_busy;
  assign load  = offer && (free_q >= PKT_CNT);
  assign drop  = offer && (free_q <  PKT_CNT);
  assign pop   = rd_req && (level_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      free_q  <= CNT_W'(DEPTH);
      err_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_q + PTR_W'(wr_en);
      rptr_q  <= rptr_q + PTR_W'(pop);
      level_q <= level_q + CNT_W'(wr_en) - CNT_W'(pop);
      free_q  <= free_q + CNT_W'(pop) - (load ? PKT_CNT : '0);
      if (drop) begin
        err_q <= 1'b1;
      end else if (err_clr) begin
        err_q <= 1'b0;
      end
    end
  end

  assign wr_addr    = wptr_q;
  assign rd_addr    = rptr_q;
  assign empty      = (level_q == '0);
  assign free_words = free_q;
  assign drop_err   = err_q;
endmodule

// File: rtl/rbf_top.sv
module rbf_top #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pkt_valid,
  input  logic [PKT_WORDS*DATA_W-1:0]   pkt_data,
  output logic                          pkt_ready,
  input  logic                          rd_req,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          empty,
  output logic [$clog2(DEPTH+1)-1:0]    free_words,
  output logic                          drop_err,
  input  logic                          drop_err_clr
);
  localparam int PTR_W = $clog2(DEPTH);

  logic              busy, wr_en, load, pop;
  logic [DATA_W-1:0] wr_data, ram_q;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic              zero_q;

  rbf_stager #(.DATA_W(DATA_W), .PKT_WORDS(PKT_WORDS)) u_stager (
    .clk(clk), .rst(rst), .load(load), .pkt_data(pkt_data),
    .busy(busy), .wr_en(wr_en), .wr_data(wr_data)
  );

  rbf_ctrl #(.DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .stage_busy(busy),
    .wr_en(wr_en), .rd_req(rd_req), .err_clr(drop_err_clr),
    .load(load), .pop(pop), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .empty(empty), .free_words(free_words), .drop_err(drop_err)
  );

  rbf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(pop), .rd_addr(rd_addr), .rd_q(ram_q)
  );

  // A read of an empty store yields zero on the following cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q <= 1'b1;
    end else if (rd_req) begin
      zero_q <= !pop;
    end
  end

  assign rd_data   = zero_q ? '0 : ram_q;
  assign pkt_ready = !busy;
endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        pkt_valid,
  input logic                        pkt_ready,
  input logic                        rd_req,
  input logic [DATA_W-1:0]           rd_data,
  input logic                        empty,
  input logic [$clog2(DEPTH+1)-1:0]  free_words,
  input logic                        drop_err,
  input logic                        drop_err_clr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] PKT_CNT = CNT_W'(PKT_WORDS);

  p_drop_keeps_free_r3: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready && free_words < PKT_CNT && !rd_req)
      |=> (free_words == $past(free_words)) && drop_err);

  p_empty_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> (rd_data == '0) && (free_words == $past(free_words)));

  p_accept_free_r6: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready && free_words >= PKT_CNT && !rd_req)
      |=> free_words == $past(free_words) - PKT_CNT);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready && free_words >= PKT_CNT) |=> !pkt_ready);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (drop_err && !drop_err_clr) |=> drop_err);

  p_capacity_r11: assert property (@(posedge clk) disable iff (rst)
    free_words <= CNT_W'(DEPTH));
endmodule

bind rbf_top rbf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)) u_chk (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .rd_req(rd_req), .rd_data(rd_data), .empty(empty), .free_words(free_words),
  .drop_err(drop_err), .drop_err_clr(drop_err_clr)
);

// File: tb/rbf_top_test.sv
module rbf_top_test;
  localparam int DW  = 32;
  localparam int DEP = 2048;
  localparam int PW  = 4;
  localparam int CW  = $clog2(DEP + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pv = 1'b0, rq = 1'b0, clr = 1'b0;
  logic [PW*DW-1:0]  pd = '0;
  logic              pkt_ready, empty, drop_err;
  logic [DW-1:0]     rd_data;
  logic [CW-1:0]     free_words;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference
  logic [DW-1:0] mq[$];
  logic [DW-1:0] mpend[$];
  int            mfree;
  bit            merr;
  logic [DW-1:0] mrd;

  always #4 clk = ~clk;

  rbf_top #(.DATA_W(DW), .DEPTH(DEP), .PKT_WORDS(PW)) uut (
    .clk(clk), .rst(rst), .pkt_valid(pv), .pkt_data(pd), .pkt_ready(pkt_ready),
    .rd_req(rq), .rd_data(rd_data), .empty(empty), .free_words(free_words),
    .drop_err(drop_err), .drop_err_clr(clr)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    bit ready_pre, drop;
    int free_pre;
    ready_pre = (mpend.size() == 0);
    free_pre  = mfree;
    drop      = 0;
    if (rq) begin
      if (mq.size() > 0) begin
        mrd = mq.pop_front();
        mfree++;
      end else begin
        mrd = '0;
      end
    end
    if (mpend.size() > 0) mq.push_back(mpend.pop_front());
    if (pv && ready_pre) begin
      if (free_pre >= PW) begin
        for (int i = 0; i < PW; i++) mpend.push_back(pd[i*DW +: DW]);
        mfree -= PW;
      end else begin
        drop = 1;
      end
    end
    if (drop) merr = 1;
    else if (clr) merr = 0;
  endtask

  task automatic compare_all();
    chk("R8 empty", DW'(empty), DW'(mq.size() == 0));
    chk("R6 free_words", DW'(free_words), DW'(mfree));
    chk("R9 drop_err", DW'(drop_err), DW'(merr));
    chk("R7 pkt_ready", DW'(pkt_ready), DW'(mpend.size() == 0));
    chk("R5 rd_data", rd_data, mrd);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [PW*DW-1:0] mkpkt(input logic [DW-1:0] base);
    logic [PW*DW-1:0] p;
    for (int i = 0; i < PW; i++) p[i*DW +: DW] = base + DW'(i);
    return p;
  endfunction

  task automatic push(input logic [DW-1:0] base, input bit with_rd);
    pv = 1; pd = mkpkt(base); rq = with_rd;
    step();
    pv = 0; rq = 0;
  endtask

  task automatic rd1();
    rq = 1; step(); rq = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mfree = DEP; merr = 0; mrd = '0;
    // R1 reset state
    chk("R1 empty", DW'(empty), 1);
    chk("R1 free_words", DW'(free_words), DW'(DEP));
    chk("R1 drop_err", DW'(drop_err), 0);
    chk("R1 pkt_ready", DW'(pkt_ready), 1);
    chk("R1 rd_data", rd_data, 0);

    // R2/R8: one packet in, read back in order
    push(32'hA000_0000, 0);
    // R7: packet offered while staging busy is ignored
    pv = 1; pd = mkpkt(32'hB000_0000); step(); pv = 0;
    chk("R8 empty low after first word", DW'(empty), 0);
    repeat (3) step();
    chk("R7 ready restored", DW'(pkt_ready), 1);
    chk("R7 busy offer ignored", DW'(free_words), DW'(DEP - PW));
    for (int i = 0; i < PW; i++) begin
      rd1();
      chk($sformatf("R2 word %0d", i), rd_data, 32'hA000_0000 + DW'(i));
    end

    // R4: read of empty store
    rd1();
    chk("R4 rd_data zero", rd_data, 0);
    chk("R4 free unchanged", DW'(free_words), DW'(DEP));
    step();
    chk("R4 empty kept", DW'(empty), 1);

    // R11: fill to capacity
    for (int k = 0; k < DEP / PW; k++) begin
      push(DW'(k) << 4, 0);
      repeat (PW) step();
    end
    chk("R11 free zero at full", DW'(free_words), 0);

    // R3: overflow discarded, R9 set
    push(32'hDEAD_0000, 0);
    chk("R3 free after drop", DW'(free_words), 0);
    chk("R9 err set", DW'(drop_err), 1);
    clr = 1; step(); clr = 0;
    chk("R9 err cleared", DW'(drop_err), 0);
    // R9: drop with clear in the same cycle keeps it set
    pv = 1; pd = mkpkt(32'hDEAD_1000); clr = 1; step(); pv = 0; clr = 0;
    chk("R9 set wins over clear", DW'(drop_err), 1);
    clr = 1; step(); clr = 0;

    // R10: three free, offer with simultaneous pop -> dropped
    repeat (3) rd1();
    chk("R10 free three", DW'(free_words), 3);
    push(32'hC000_0000, 1);
    chk("R10 dropped on pre-pop count", DW'(drop_err), 1);
    chk("R10 free after pop", DW'(free_words), 4);
    clr = 1; step(); clr = 0;
    push(32'hE000_0000, 0);
    repeat (PW) step();
    chk("R11 last packet fits", DW'(free_words), 0);

    // drain everything, then one more read of empty
    while (mq.size() > 0) rd1();
    rd1();
    chk("R4 drained read zero", rd_data, 0);
    chk("R1 back to empty", DW'(empty), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule